// File: doc/BRIEF.md
# Ready-Gated Full-Duplex Serial Word Master

This block moves one fixed-length word (24 bits by default) in each direction over a four-wire serial link to a touch-sensing slave. A host on the chip presents a command word with a one-cycle request strobe. The block waits until the slave reports that it is ready, then lowers chip select. It holds a long setup interval before the first clock edge. It then clocks the word out most-significant bit first while it captures the slave's reply. When chip select rises again, the reply is returned with a one-cycle done strobe.

The serial clock idles high. In each bit, the master drops the clock, puts the next command bit on its data output, and raises the clock again. The slave's data line is captured at that rising edge. The setup interval and the clock half-period are parameters counted in system clock cycles. At a 100 MHz system clock, the defaults give 25 µs and 10 µs. The slave's ready and change lines are asynchronous and pass through a two-flop synchronizer. The synchronized change line is exposed as a status flag, so a controller can wait for fresh slave data.

The control is a six-state machine. State ST_IDLE goes to ST_WAIT_RDY when a request is accepted. ST_WAIT_RDY goes to ST_SETUP when synchronized ready is high. ST_SETUP goes to ST_CLK_LO when the setup timer expires. ST_CLK_LO goes to ST_CLK_HI when the half-period timer expires, and the incoming bit is shifted in at that point. ST_CLK_HI goes back to ST_CLK_LO when its timer expires and bits remain. After the last bit it goes to ST_DONE. ST_DONE always returns to ST_IDLE after one cycle.

Top module: `touch_link_master`

## Requirements
- R1: After reset and whenever chip select is high, chip select and serial clock both read 1, busy and done read 0, and the serial clock never toggles while chip select is high.
- R2: A request is taken only when the block is idle. Busy is 1 from the cycle after the accepted request through the done cycle, and 0 the cycle after done.
- R3: Chip select stays high for as long as the slave's ready input is low, however long that is.
- R4: When ready rises while a request is waiting, chip select falls exactly 3 cycles later: two synchronizer stages plus one state step.
- R5: The first falling edge of the serial clock comes exactly SETUP_CYC cycles after chip select falls.
- R6: Every low phase of the serial clock lasts exactly HALF_CYC cycles. So does every high phase between two low phases.
- R7: Each frame has exactly FRAME_BITS rising edges of the serial clock.
- R8: The data output carries the command word most-significant bit first. It changes only in the cycle where the serial clock falls, and it is stable while the clock is high.
- R9: The data input is sampled at each rising edge of the serial clock. The first sample becomes the most significant bit of the response.
- R10: Chip select rises HALF_CYC cycles after the last rising edge, with the clock high. Done is 1 for exactly that one cycle, and the response output holds the captured word while done is 1.
- R11: The status flag equals the slave's change input delayed by two cycles.
- R12: A request strobe that arrives while busy is 1 is dropped. It does not alter the frame in progress, and it does not start a later transfer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | One-cycle request strobe |
| req_cmd | input | FRAME_BITS | Command word to send |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion strobe |
| resp_data | output | FRAME_BITS | Word captured from the slave |
| new_data | output | 1 | Synchronized slave change flag |
| spi_cs_n | output | 1 | Chip select, active low, idles high |
| spi_sclk | output | 1 | Serial clock, idles high |
| spi_mosi | output | 1 | Serial data to the slave |
| spi_miso | input | 1 | Serial data from the slave |
| slave_ready | input | 1 | Slave ready, asynchronous |
| slave_change | input | 1 | Slave change indication, asynchronous |

## Verification
The hardest situation to reach is a request that sits in ST_WAIT_RDY while ready is held low for a long and varying time. A further request strobe landing mid-frame is also hard to reach. Neither shows up with a slave that is always ready. The bench drops ready before each request and holds it low for a number of cycles that varies across a walking-bit sweep, including one very long stall. On some transfers it fires a second request with an inverted command just after chip select falls. It then verifies that the captured frame still matches the first command and that the link stays quiet afterwards.

// File: rtl/tl_pkg.sv
package tl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_WAIT_RDY = 3'd1,
        ST_SETUP    = 3'd2,
        ST_CLK_LO   = 3'd3,
        ST_CLK_HI   = 3'd4,
        ST_DONE     = 3'd5
    } tl_state_e;

endpackage

// File: rtl/tl_sync.sv
module tl_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[0] <= '0;
                else        stage_q[0] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[s] <= '0;
                else        stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign q = stage_q[STAGES-1];

endmodule

// File: rtl/tl_timer.sv
module tl_timer #(
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/tl_shifter.sv
module tl_shifter #(
    parameter int BITS = 24
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [BITS-1:0] load_word,
    input  logic            shift,
    input  logic            ser_in,
    output logic [BITS-1:0] word
);

    logic [BITS-1:0] word_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= '0;
        end else if (load) begin
            word_q <= load_word;
        end else if (shift) begin
            word_q <= {word_q[BITS-2:0], ser_in};
        end
    end

    assign word = word_q;

endmodule

// File: rtl/touch_link_master.sv
module touch_link_master
    import tl_pkg::*;
#(
    parameter int FRAME_BITS = 24,
    parameter int SETUP_CYC  = 2500,
    parameter int HALF_CYC   = 1000
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic [FRAME_BITS-1:0] req_cmd,
    output logic                  busy,
    output logic                  done,
    output logic [FRAME_BITS-1:0] resp_data,
    output logic                  new_data,
    output logic                  spi_cs_n,
    output logic                  spi_sclk,
    output logic                  spi_mosi,
    input  logic                  spi_miso,
    input  logic                  slave_ready,
    input  logic                  slave_change
);

    localparam int TMAX = (SETUP_CYC > HALF_CYC) ? SETUP_CYC : HALF_CYC;
    localparam int TW   = $clog2(TMAX + 1);
    localparam int BW   = $clog2(FRAME_BITS + 1);
    localparam logic [TW-1:0] SETUP_LOAD = TW'(SETUP_CYC - 1);
    localparam logic [TW-1:0] HALF_LOAD  = TW'(HALF_CYC - 1);
    localparam logic [BW-1:0] LAST_BIT   = BW'(FRAME_BITS - 1);

    // Synchronized slave status lines.
    logic [1:0] sync_in;
    logic [1:0] sync_out;
    logic       rdy_sync;

    assign sync_in = {slave_change, slave_ready};

    tl_sync #(
        .WIDTH (2),
        .STAGES(2)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (sync_in),
        .q    (sync_out)
    );

    assign rdy_sync = sync_out[0];
    assign new_data = sync_out[1];

    // State machine controls.
    tl_state_e       state_q;
    tl_state_e       state_d;
    logic            tmr_load;
    logic [TW-1:0]   tmr_val;
    logic            tmr_done;
    logic            sh_load;
    logic            sh_shift;
    logic [FRAME_BITS-1:0] sh_word;
    logic [BW-1:0]   bit_cnt;
    logic            bit_clr;
    logic            bit_inc;

    tl_timer #(
        .CW(TW)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .load_val(tmr_val),
        .expired (tmr_done)
    );

    tl_shifter #(
        .BITS(FRAME_BITS)
    ) u_shifter (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (sh_load),
        .load_word(req_cmd),
        .shift    (sh_shift),
        .ser_in   (spi_miso),
        .word     (sh_word)
    );

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Bit position counter.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0;
        end else if (bit_clr) begin
            bit_cnt <= '0;
        end else if (bit_inc) begin
            bit_cnt <= bit_cnt + 1'b1;
        end
    end

    // Next-state and datapath control.
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = HALF_LOAD;
        sh_load  = 1'b0;
        sh_shift = 1'b0;
        bit_clr  = 1'b0;
        bit_inc  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    state_d = ST_WAIT_RDY;
                    sh_load = 1'b1;
                end
            end
            ST_WAIT_RDY: begin
                if (rdy_sync) begin
                    state_d  = ST_SETUP;
                    tmr_load = 1'b1;
                    tmr_val  = SETUP_LOAD;
                    bit_clr  = 1'b1;
                end
            end
            ST_SETUP: begin
                if (tmr_done) begin
                    state_d  = ST_CLK_LO;
                    tmr_load = 1'b1;
                end
            end
            ST_CLK_LO: begin
                if (tmr_done) begin
                    state_d  = ST_CLK_HI;
                    tmr_load = 1'b1;
                    sh_shift = 1'b1;
                end
            end
            ST_CLK_HI: begin
                if (tmr_done) begin
                    if (bit_cnt == LAST_BIT) begin
                        state_d = ST_DONE;
                    end else begin
                        state_d  = ST_CLK_LO;
                        tmr_load = 1'b1;
                        bit_inc  = 1'b1;
                    end
                end
            end
            ST_DONE: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // Registered outputs, decoded from the next state.
    logic                  cs_n_q;
    logic                  sclk_q;
    logic                  mosi_q;
    logic                  busy_q;
    logic                  done_q;
    logic [FRAME_BITS-1:0] resp_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_n_q <= 1'b1;
            sclk_q <= 1'b1;
            mosi_q <= 1'b1;
            busy_q <= 1'b0;
            done_q <= 1'b0;
            resp_q <= '0;
        end else begin
            cs_n_q <= !((state_d == ST_SETUP) || (state_d == ST_CLK_LO) ||
                        (state_d == ST_CLK_HI));
            sclk_q <= (state_d != ST_CLK_LO);
            if ((state_d == ST_CLK_LO) && (state_q != ST_CLK_LO)) begin
                mosi_q <= sh_word[FRAME_BITS-1];
            end
            busy_q <= (state_d != ST_IDLE);
            done_q <= (state_d == ST_DONE);
            if (state_d == ST_DONE) begin
                resp_q <= sh_word;
            end
        end
    end

    assign spi_cs_n  = cs_n_q;
    assign spi_sclk  = sclk_q;
    assign spi_mosi  = mosi_q;
    assign busy      = busy_q;
    assign done      = done_q;
    assign resp_data = resp_q;

endmodule

// File: rtl/tl_checker.sv
module tl_checker #(
    parameter int FRAME_BITS = 24,
    parameter int SETUP_CYC  = 2500,
    parameter int HALF_CYC   = 1000
) (
    input logic clk,
    input logic rst_n,
    input logic spi_cs_n,
    input logic spi_sclk,
    input logic spi_mosi,
    input logic busy,
    input logic done,
    input logic rdy_sync
);

    localparam int TMAX = (SETUP_CYC > HALF_CYC) ? SETUP_CYC : HALF_CYC;
    localparam int CW   = $clog2(TMAX + 2);
    localparam int BW   = $clog2(FRAME_BITS + 2);

    logic          sclk_q;
    logic          csn_q;
    logic [CW-1:0] run;
    logic          first_hi;
    logic [BW-1:0] falls;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_q   <= 1'b1;
            csn_q    <= 1'b1;
            run      <= '0;
            first_hi <= 1'b0;
            falls    <= '0;
        end else begin
            sclk_q <= spi_sclk;
            csn_q  <= spi_cs_n;
            if ((spi_sclk != sclk_q) || (spi_cs_n != csn_q)) begin
                run <= CW'(1);
            end else if (run != '1) begin
                run <= run + 1'b1;
            end
            if (csn_q && !spi_cs_n) begin
                first_hi <= 1'b1;
                falls    <= '0;
            end else if (sclk_q && !spi_sclk) begin
                first_hi <= 1'b0;
                falls    <= falls + 1'b1;
            end
        end
    end

    a_r1_clock_high_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> spi_sclk);

    a_r3_select_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(spi_cs_n) |-> $past(rdy_sync));

    a_r2_done_inside_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    a_r2_accept_before_select: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> spi_cs_n);

    a_r10_done_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r10_release_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spi_cs_n) |-> (done && spi_sclk));

    a_r8_mosi_moves_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(spi_mosi) |-> $fell(spi_sclk));

    a_r6_low_phase_width: assert property (@(posedge clk) disable iff (!rst_n)
        (!sclk_q && spi_sclk) |-> (run == CW'(HALF_CYC)));

    a_r5_high_phase_width: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_q && !spi_sclk) |->
            (run == (first_hi ? CW'(SETUP_CYC) : CW'(HALF_CYC))));

    a_r7_frame_length: assert property (@(posedge clk) disable iff (!rst_n)
        (!csn_q && spi_cs_n) |->
            ((falls == BW'(FRAME_BITS)) && (run == CW'(HALF_CYC))));

endmodule

bind touch_link_master tl_checker #(
    .FRAME_BITS(FRAME_BITS),
    .SETUP_CYC (SETUP_CYC),
    .HALF_CYC  (HALF_CYC)
) u_tl_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .spi_cs_n(spi_cs_n),
    .spi_sclk(spi_sclk),
    .spi_mosi(spi_mosi),
    .busy    (busy),
    .done    (done),
    .rdy_sync(rdy_sync)
);

// File: tb/touch_link_master_bench.sv
`timescale 1ns/1ps
module touch_link_master_bench;

    localparam int FB = 24;
    localparam int SU = 5;
    localparam int HC = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [FB-1:0] req_cmd = '0;
    logic          busy, done, new_data;
    logic [FB-1:0] resp_data;
    logic          spi_cs_n, spi_sclk, spi_mosi;
    logic          spi_miso = 1'b0;
    logic          slave_ready = 1'b0;
    logic          slave_change = 1'b0;

    touch_link_master #(
        .FRAME_BITS(FB),
        .SETUP_CYC (SU),
        .HALF_CYC  (HC)
    ) u_touch_link_master (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_cmd     (req_cmd),
        .busy        (busy),
        .done        (done),
        .resp_data   (resp_data),
        .new_data    (new_data),
        .spi_cs_n    (spi_cs_n),
        .spi_sclk    (spi_sclk),
        .spi_mosi    (spi_mosi),
        .spi_miso    (spi_miso),
        .slave_ready (slave_ready),
        .slave_change(slave_change)
    );

    always #2 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    // Slave model and pin monitor, sampled on the falling clock edge.
    logic [FB-1:0] slave_word = '0;
    logic [FB-1:0] cap = '0;
    logic          prev_cs = 1'b1;
    logic          prev_sclk = 1'b1;
    logic          prev_mosi = 1'b1;
    bit            first_fall = 1'b0;
    int            last_evt = 0;
    int            setup_meas = 0;
    int            tail_meas = 0;
    int            rises = 0;
    int            falls = 0;
    int            tim_err = 0;
    int            mosi_err = 0;
    int            idle_toggle = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_cs && !spi_cs_n) begin
                last_evt   = cyc;
                first_fall = 1'b1;
                rises      = 0;
                falls      = 0;
                cap        = '0;
                tim_err    = 0;
                mosi_err   = 0;
            end
            if (!prev_cs && spi_cs_n) begin
                tail_meas = cyc - last_evt;
            end
            if (prev_sclk != spi_sclk) begin
                if (spi_cs_n) idle_toggle++;
                if (!spi_sclk) begin
                    if (first_fall) setup_meas = cyc - last_evt;
                    else if (cyc - last_evt != HC) tim_err++;
                    first_fall = 1'b0;
                    if (falls < FB) spi_miso = slave_word[FB-1-falls];
                    falls++;
                end else begin
                    if (cyc - last_evt != HC) tim_err++;
                    cap = {cap[FB-2:0], spi_mosi};
                    rises++;
                end
                last_evt = cyc;
            end
            if (!spi_cs_n && spi_sclk && prev_sclk && (spi_mosi != prev_mosi))
                mosi_err++;
            prev_cs   = spi_cs_n;
            prev_sclk = spi_sclk;
            prev_mosi = spi_mosi;
        end
    end

    task automatic run_txn(input logic [FB-1:0] cmd, input logic [FB-1:0] sw,
                           input int rdy_delay, input bit inject);
        int n;
        int cs_low_in_stall;
        int busy_low;
        slave_ready = 1'b0;
        repeat (4) @(negedge clk);
        slave_word = sw;
        req_cmd    = cmd;
        req_valid  = 1'b1;
        @(negedge clk);
        req_valid  = 1'b0;
        chk(busy == 1'b1, "R2", "busy after accept", 32'(busy), 1);
        cs_low_in_stall = 0;
        for (int i = 0; i < rdy_delay; i++) begin
            @(negedge clk);
            if (!spi_cs_n) cs_low_in_stall++;
        end
        if (rdy_delay > 0)
            chk(cs_low_in_stall == 0, "R3", "select during ready stall", 32'(cs_low_in_stall), 0);
        slave_ready = 1'b1;
        n = 0;
        while (spi_cs_n && n < 20) begin
            @(negedge clk);
            n++;
        end
        chk(n == 3, "R4", "ready to select latency", 32'(n), 3);
        if (inject) begin
            @(negedge clk);
            req_cmd   = ~cmd;
            req_valid = 1'b1;
            @(negedge clk);
            req_valid = 1'b0;
        end
        busy_low = 0;
        n = 0;
        while (!done && n < 5000) begin
            if (!busy) busy_low++;
            @(negedge clk);
            n++;
        end
        chk(done == 1'b1, "R10", "done seen", 32'(done), 1);
        chk(busy_low == 0, "R2", "busy gap during transfer", 32'(busy_low), 0);
        chk(resp_data == sw, "R9", "response word", 32'(resp_data), 32'(sw));
        chk(spi_cs_n && spi_sclk, "R10", "select released with clock high",
            {30'd0, spi_cs_n, spi_sclk}, 3);
        @(negedge clk);
        #1;
        chk(done == 1'b0, "R10", "done single cycle", 32'(done), 0);
        chk(busy == 1'b0, "R2", "busy clears after done", 32'(busy), 0);
        chk(rises == FB, "R7", "rising edges per frame", 32'(rises), 32'(FB));
        chk(cap == cmd, "R8", "command bits on mosi", 32'(cap), 32'(cmd));
        chk(mosi_err == 0, "R8", "mosi stable while clock high", 32'(mosi_err), 0);
        chk(setup_meas == SU, "R5", "select setup cycles", 32'(setup_meas), 32'(SU));
        chk(tim_err == 0, "R6", "half-period violations", 32'(tim_err), 0);
        chk(tail_meas == HC, "R10", "last rise to release", 32'(tail_meas), 32'(HC));
        if (inject) begin
            n = 0;
            for (int i = 0; i < 20; i++) begin
                @(negedge clk);
                if (!spi_cs_n || busy) n++;
            end
            chk(n == 0, "R12", "dropped request stayed dropped", 32'(n), 0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [FB-1:0] c;
        logic [FB-1:0] s;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(spi_cs_n && spi_sclk, "R1", "pins idle in reset", {30'd0, spi_cs_n, spi_sclk}, 3);
        chk(!busy && !done, "R1", "status idle in reset", {30'd0, busy, done}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(spi_cs_n && spi_sclk && !busy, "R1", "idle after reset",
            {29'd0, spi_cs_n, spi_sclk, busy}, 6);

        // R11: change flag latency
        slave_change = 1'b1;
        @(negedge clk);
        chk(new_data == 1'b0, "R11", "flag after one cycle", 32'(new_data), 0);
        @(negedge clk);
        chk(new_data == 1'b1, "R11", "flag after two cycles", 32'(new_data), 1);
        slave_change = 1'b0;
        @(negedge clk);
        chk(new_data == 1'b1, "R11", "flag holds one cycle", 32'(new_data), 1);
        @(negedge clk);
        chk(new_data == 1'b0, "R11", "flag clears", 32'(new_data), 0);

        run_txn(24'h000000, 24'hFFFFFF, 0, 1'b0);
        run_txn(24'hFFFFFF, 24'h000000, 1, 1'b0);
        run_txn(24'hA5C33C, 24'h5A3CC3, 2, 1'b1);
        run_txn(24'h123456, 24'hFEDCBA, 60, 1'b0);

        for (int i = 0; i < FB; i++) begin
            c = FB'(1) << i;
            s = ~c;
            run_txn(c, s, i % 5, (i % 6) == 0);
        end
        for (int i = 0; i < 8; i++) begin
            c = FB'(i * 32'h0002F1B3 + 7);
            s = c ^ 24'hC0FFEE;
            run_txn(c, s, 3, 1'b0);
        end

        chk(idle_toggle == 0, "R1", "clock toggles while deselected", 32'(idle_toggle), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule